// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block holds the interrupt control state of a serial port. Event generators elsewhere in the port send one-cycle pulses, one per condition. Each pulse sets a sticky pending bit. Software sees these pending bits on a plain 32-bit register bus that has separate read and write strobes and a byte address. Software turns individual sources on through a set-only register and off through a clear-only register. The resulting mask is readable but cannot be written directly. Software clears a pending bit by writing a 1 to it. A separate view shows the live level of each condition, so software can poll a condition whose interrupt is masked.

The single interrupt output is the registered OR of the pending bits that are also enabled. Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd` and is zero when no read is under way. A write takes effect on the rising clock edge that samples `bus_wr`. The bus has no back-pressure. Every strobe completes in one cycle.

Top module: `irq_ctrl_regs`

## Requirements
- R1: A write to offset 0x08 sets every mask bit whose data bit is 1. Mask bits written as 0 keep their value. The mask reads back at offset 0x10.
- R2: A write to offset 0x0C clears every mask bit whose data bit is 1. Mask bits written as 0 keep their value.
- R3: A read of offset 0x08 or 0x0C returns 0. A read of any unmapped offset also returns 0.
- R4: Bit i of the mask, the pending, the live and the event vectors all name the same source. Bit 0 is receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing, 7 parity and 8 timeout. Bits 9 to 12 are spare sources. Only bits 12:0 (mask 0x1FFF) exist: bits 31:13 read as 0 and ignore writes.
- R5: A pulse on `evt_pulse[i]` sets pending bit i at the next clock edge. The bit stays set until software clears it.
- R6: A write to offset 0x14 clears every pending bit whose data bit is 1 and leaves the others. Writing back the value just read clears all pending bits.
- R7: When an event pulse and a write-1-clear of the same pending bit fall in the same cycle, the bit stays set.
- R8: Pending bits latch whatever the mask holds. Changing the mask never changes a pending bit.
- R9: A read of offset 0x2C returns `live_cond`, whatever the mask holds.
- R10: `irq` is high one cycle after some bit is both pending and enabled, and low one cycle after no such bit remains.
- R11: After reset the mask is 0, no bit is pending and `irq` is 0.
- R12: A write to offset 0x10 (mask view) or 0x2C (live view) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, else 0 |
| evt_pulse | input | SRC_W (13) | One-cycle event pulses, one per source |
| live_cond | input | SRC_W (13) | Live condition levels for the status view |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse and a write-1-clear of the same bit in the same cycle. The bench first fills the pending register with a full sweep of pulses. It then drives a clear write to offset 0x14 and a chosen event pattern on the same falling edge, so that both land on one rising edge. It reads back afterwards and expects exactly the event pattern to remain. Each source bit is also walked alone through enable, pulse, disable and clear. This separates the irq delay from the mask and pending behaviour, bit by bit.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned OFS_ENABLE  = 32'h08;
  localparam int unsigned OFS_DISABLE = 32'h0C;
  localparam int unsigned OFS_MASK    = 32'h10;
  localparam int unsigned OFS_PENDING = 32'h14;
  localparam int unsigned OFS_LIVE    = 32'h2C;

  localparam int unsigned BIT_RX_TRIG  = 0;
  localparam int unsigned BIT_RX_EMPTY = 1;
  localparam int unsigned BIT_RX_FULL  = 2;
  localparam int unsigned BIT_TX_EMPTY = 3;
  localparam int unsigned BIT_TX_FULL  = 4;
  localparam int unsigned BIT_OVERRUN  = 5;
  localparam int unsigned BIT_FRAMING  = 6;
  localparam int unsigned BIT_PARITY   = 7;
  localparam int unsigned BIT_TIMEOUT  = 8;

  typedef enum logic [1:0] {
    RSEL_NONE    = 2'd0,
    RSEL_MASK    = 2'd1,
    RSEL_PENDING = 2'd2,
    RSEL_LIVE    = 2'd3
  } rsel_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [SRC_W-1:0]  mask_q,
  input  logic [SRC_W-1:0]  pend_q,
  input  logic [SRC_W-1:0]  live_cond,
  output logic [SRC_W-1:0]  set_req,
  output logic [SRC_W-1:0]  clr_req,
  output logic [SRC_W-1:0]  w1c_req,
  output logic [31:0]       bus_rdata
);
  localparam int PAD_W = 32 - SRC_W;

  logic [SRC_W-1:0] wbits;
  logic             hit_en, hit_dis, hit_mask, hit_pend, hit_live;
  rsel_e            rsel;
  logic [SRC_W-1:0] rsrc;

  assign wbits    = bus_wdata[SRC_W-1:0];
  assign hit_en   = (bus_addr == ADDR_W'(OFS_ENABLE));
  assign hit_dis  = (bus_addr == ADDR_W'(OFS_DISABLE));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_pend = (bus_addr == ADDR_W'(OFS_PENDING));
  assign hit_live = (bus_addr == ADDR_W'(OFS_LIVE));

  assign set_req = (bus_wr && hit_en)   ? wbits : '0;
  assign clr_req = (bus_wr && hit_dis)  ? wbits : '0;
  assign w1c_req = (bus_wr && hit_pend) ? wbits : '0;

  always_comb begin
    rsel = RSEL_NONE;
    if (bus_rd) begin
      if (hit_mask)      rsel = RSEL_MASK;
      else if (hit_pend) rsel = RSEL_PENDING;
      else if (hit_live) rsel = RSEL_LIVE;
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_MASK:    rsrc = mask_q;
      RSEL_PENDING: rsrc = pend_q;
      RSEL_LIVE:    rsrc = live_cond;
      default:      rsrc = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_rdata = {{PAD_W{1'b0}}, rsrc};
    end else begin : g_nopad
      assign bus_rdata = rsrc;
    end
  endgenerate

  // R4: bits above the source width never read as 1
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> SRC_W) == 32'd0);
  // R3: no read strobe, no data
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 32'd0);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int SRC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_req,
  input  logic [SRC_W-1:0] clr_req,
  output logic [SRC_W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | set_req) & ~clr_req;
  end

  // R1: set-write turns requested bits on
  a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((mask_q & $past(set_req)) == $past(set_req)));
  // R2: clear-write turns requested bits off
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req != '0) |=> ((mask_q & $past(clr_req)) == '0));
  // R12: no mask request, no mask change
  a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req == '0 && clr_req == '0) |=> $stable(mask_q));
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int SRC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_pulse,
  input  logic [SRC_W-1:0] w1c_req,
  output logic [SRC_W-1:0] pend_q
);
  generate
    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pend_q[i] <= 1'b0;
        else if (evt_pulse[i]) pend_q[i] <= 1'b1;
        else if (w1c_req[i])   pend_q[i] <= 1'b0;
      end
    end
  endgenerate

  // R5 and R7: an event always leaves its bit set
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((pend_q & $past(evt_pulse)) == $past(evt_pulse)));
  // R6: a clear without a competing event empties the bit
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1c_req & ~evt_pulse) != '0) |=> ((pend_q & $past(w1c_req & ~evt_pulse)) == '0));
  // R8: pending bits change only on events or clears
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse == '0 && w1c_req == '0) |=> $stable(pend_q));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SRC_W-1:0]  evt_pulse,
  input  logic [SRC_W-1:0]  live_cond,
  output logic              irq
);
  logic [SRC_W-1:0] set_req, clr_req, w1c_req;
  logic [SRC_W-1:0] mask_q, pend_q;
  logic             irq_q;

  irq_bus_decode #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .live_cond (live_cond),
    .set_req   (set_req),
    .clr_req   (clr_req),
    .w1c_req   (w1c_req),
    .bus_rdata (bus_rdata)
  );

  irq_mask_reg #(.SRC_W(SRC_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .mask_q  (mask_q)
  );

  irq_pending_reg #(.SRC_W(SRC_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .w1c_req   (w1c_req),
    .pend_q    (pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_q & mask_q);
  end

  assign irq = irq_q;

  // R10: request follows enabled pending bits one cycle later
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) != '0) |=> irq);
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) == '0) |=> !irq);
endmodule

// File: tb/test_irq_ctrl_regs.sv
module test_irq_ctrl_regs;
  localparam int ADDR_W = 8;
  localparam int SRC_W  = 13;
  localparam logic [31:0] VALID = 32'h0000_1FFF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [SRC_W-1:0]  evt_pulse = '0;
  logic [SRC_W-1:0]  live_cond = '0;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_mask = '0;
  logic [31:0] exp_pend = '0;

  always #10 clk = ~clk;

  irq_ctrl_regs #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) i_irq_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .live_cond(live_cond), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [SRC_W-1:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
    exp_pend = exp_pend | 32'(ev);
  endtask

  task automatic irq_chk(input string tag);
    @(negedge clk);
    @(negedge clk);
    chk(tag, {31'd0, irq}, {31'd0, |(exp_pend & exp_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd_chk("R11 mask after reset", 8'h10, 32'd0);
    rd_chk("R11 pending after reset", 8'h14, 32'd0);
    chk("R11 irq after reset", {31'd0, irq}, 32'd0);
    // R3 write-only and unmapped reads
    rd_chk("R3 enable reads zero", 8'h08, 32'd0);
    rd_chk("R3 disable reads zero", 8'h0C, 32'd0);
    rd_chk("R3 unmapped reads zero", 8'h04, 32'd0);

    // R1 R2 R5 R8 R10: walk each source bit alone
    for (int i = 0; i < SRC_W; i++) begin
      logic [31:0] b;
      b = 32'd1 << i;
      wr(8'h08, b); exp_mask |= b;
      rd_chk("R1 single enable", 8'h10, exp_mask);
      pulse(SRC_W'(b));
      rd_chk("R5 pending latched", 8'h14, exp_pend);
      irq_chk("R10 irq raised");
      wr(8'h0C, b); exp_mask &= ~b;
      rd_chk("R2 single disable", 8'h10, exp_mask);
      rd_chk("R8 pending kept when masked", 8'h14, exp_pend);
      irq_chk("R10 irq dropped");
      wr(8'h14, b); exp_pend &= ~b;
      rd_chk("R6 single clear", 8'h14, exp_pend);
    end

    // R4 upper bits ignored and read zero
    wr(8'h08, 32'hFFFF_FFFF); exp_mask = VALID;
    rd_chk("R4 enable all bits", 8'h10, VALID);
    // R12 writes to read-only views change nothing
    wr(8'h10, 32'd0);
    rd_chk("R12 mask view write ignored", 8'h10, VALID);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_chk("R12 live view write ignored", 8'h14, 32'd0);

    // pattern sweep: masks, events, partial clears
    for (int p = 1; p < 24; p++) begin
      logic [31:0] m, e, c;
      m = (p * 32'h0A5B) & VALID;
      e = ((p * 32'h1379) ^ (p << 5)) & VALID;
      c = (p * 32'h0F0F) & VALID;
      wr(8'h0C, VALID); exp_mask = 32'd0;
      wr(8'h08, m | 32'hFFFF_E000); exp_mask = m;
      rd_chk("R1 pattern enable", 8'h10, exp_mask);
      wr(8'h0C, c); exp_mask &= ~c;
      rd_chk("R2 pattern disable", 8'h10, exp_mask);
      pulse(SRC_W'(e));
      rd_chk("R5 pattern pending", 8'h14, exp_pend);
      irq_chk("R10 pattern irq");
      wr(8'h14, c); exp_pend &= ~c;
      rd_chk("R6 pattern partial clear", 8'h14, exp_pend);
      live_cond = SRC_W'(e ^ c);
      rd_chk("R9 live view", 8'h2C, (e ^ c));
      wr(8'h14, exp_pend); exp_pend = 32'd0;
      rd_chk("R6 write back clears all", 8'h14, 32'd0);
      irq_chk("R10 irq after clear");
    end

    // R7 event and clear in the same cycle
    pulse(SRC_W'(VALID));
    rd_chk("R7 setup all pending", 8'h14, VALID);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = VALID; evt_pulse = 13'h0055;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
    exp_pend = 32'h0000_0055;
    rd_chk("R7 event beats clear", 8'h14, exp_pend);

    // R9 live view independent of mask
    wr(8'h0C, VALID); exp_mask = 32'd0;
    live_cond = 13'h1ABC;
    rd_chk("R9 live with mask off", 8'h2C, 32'h0000_1ABC);
    irq_chk("R10 irq off with mask clear");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule